// File: doc/BRIEF.md
# Bus controller status word checker

This block sequences the bus-controller side of a single serial-bus message and judges the status word that the addressed terminal sends back. A low level on the start input, seen while the block is idle, latches the command word. The block then runs the data words of the message across a valid/ready stream and opens a response window for the status reply. When the reply arrives it is compared against the commanded terminal and its flag bits are inspected. The block reports the start and end of the message, the final data word, a no-response time-out, a status error and an overall message error.

The command word layout the block relies on is: bits 15..11 hold the terminal address, bit 10 is the direction (1 = the terminal transmits, 0 = the controller transmits), and bits 4..0 hold the data word count. A status word carries its terminal address in bits 15..11. Its flag bits are 10, 9, 8, 4, 3, 2, 1 and 0, and bits 7..5 are reserved. Word encoding and decoding, the memory side of the data path and retry decisions belong to neighbouring blocks.

The data stream passes straight through the block. The output side is `od_valid`/`od_data` and the input side is `wd_valid`/`wd_data`. A word moves in a cycle where `wd_valid` and `wd_ready` are both high. Back-pressure from `od_ready` reaches `wd_ready` in the same cycle. Outside a data phase, both `wd_ready` and `od_valid` are held low, whatever the neighbours drive. A producer may hold `wd_valid` high for any number of cycles, and the block accepts no word that the consumer has not been offered.

Top module: `bc_stat_seq`

## Requirements
- R1: When `start_n` is low at a clock edge while the block is idle, the block latches `cmd_word`, clears `timeout`, `stat_err` and `msg_err`, and pulses `som` high for exactly the next cycle. A low `start_n` at any other time has no effect.
- R2: The data phase comes before the status window when direction bit 10 is 0, and after the accepted status when it is 1. During a data phase, `wd_ready` equals `od_ready`, `od_valid` equals `wd_valid`, and `od_data` equals `wd_data`. Outside a data phase, `wd_ready` and `od_valid` are low.
- R3: A data phase ends after the number of transfers given by command bits 4..0, and a count of 0 means 32 transfers.
- R4: `last_word` is high for exactly the cycle after the transfer of the final data word.
- R5: The status window lasts `TO_CYC` cycles, counted from the start edge (direction 1) or from the final data transfer (direction 0). A status offered in the last cycle of the window is still accepted. With no status in the window, `timeout` is set and the message ends.
- R6: An accepted status whose bits 15..11 differ from the commanded address sets `stat_err`. A `rx_stat_valid` outside the status window is ignored.
- R7: Any of status bits 10, 9, 8, 4, 3, 2, 1 or 0 set in an accepted status sets `stat_err`. Bits 7..5 never do.
- R8: `msg_err` is set whenever `timeout` or `stat_err` is set, or when `dec_err` is high during a message.
- R9: `eom_n` is low for exactly one cycle when the message completes. After that the block is idle, and the three error flags hold their values until the next start.
- R10: While reset is asserted, `som` and `last_word` are low, `eom_n` is high, `wd_ready` and `od_valid` are low, and all error flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_n | input | 1 | Message launch request, active low |
| cmd_word | input | 16 | Command word, sampled at launch |
| dec_err | input | 1 | Word decoder reported an error |
| rx_stat_valid | input | 1 | A status word is present on `rx_stat` |
| rx_stat | input | 16 | Received status word |
| wd_valid | input | 1 | Data word offered by the producer |
| wd_ready | output | 1 | Block takes the offered data word |
| wd_data | input | 16 | Data word from the producer |
| od_valid | output | 1 | Data word offered to the consumer |
| od_ready | input | 1 | Consumer can take a data word |
| od_data | output | 16 | Data word to the consumer |
| som | output | 1 | One-cycle start-of-message pulse |
| eom_n | output | 1 | End of message, low for one cycle |
| last_word | output | 1 | One-cycle pulse after the final data word |
| timeout | output | 1 | No status arrived in the window |
| stat_err | output | 1 | Status word had a wrong address or a flag set |
| msg_err | output | 1 | Any error during the message |

## Verification
On every cycle, the assertions check the single-cycle width of the `som`, `last_word` and `eom_n` pulses, and that the stream is closed outside data phases. They also check that the word and window counters stay inside their ranges, and that a time-out or a status error always carries the message error with it. Other behaviours only show up across whole scenarios in the bench. These are the exact cycle of the end pulse for a time-out, acceptance of a status in the final window cycle, the 32-word meaning of a zero count, and reserved bits that are ignored. The same holds for status words offered outside the window, and for launch requests during a busy message.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int WORD_W   = 16;
  localparam int ADDR_W   = 5;
  localparam int ADDR_LSB = 11;
  localparam int DIR_BIT  = 10;
  // status bits that count as raised flags; bits 7..5 are reserved
  localparam logic [WORD_W-1:0] FLAG_MASK = 16'h071F;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_RECV,
    ST_END
  } bcs_state_e;
endpackage

// File: rtl/bcs_word_cnt.sv
module bcs_word_cnt #(
  parameter int WC_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [WC_W-1:0] wc_field,
  input  logic            step,
  output logic            is_last
);
  localparam int CNT_W = WC_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] total;

  // a zero count field stands for the full 2**WC_W words
  assign total   = (wc_field == '0) ? CNT_W'(1 << WC_W) : {1'b0, wc_field};
  assign is_last = step && (cnt_q == total - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (load)    cnt_q <= '0;
    else if (step)    cnt_q <= is_last ? '0 : cnt_q + CNT_W'(1);
  end

  a_r3_cnt_below_total: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < total);
endmodule

// File: rtl/bcs_resp_timer.sv
module bcs_resp_timer #(
  parameter int TO_CYC = 224
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int CNT_W = (TO_CYC > 1) ? $clog2(TO_CYC) : 1;

  logic [CNT_W-1:0] cnt_q;

  assign expire = run && (cnt_q == CNT_W'(TO_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (!expire) cnt_q <= cnt_q + CNT_W'(1);
  end

  a_r5_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(TO_CYC - 1));
endmodule

// File: rtl/bcs_stat_check.sv
module bcs_stat_check
  import bcs_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [ADDR_W-1:0] exp_addr,
  output logic              addr_bad,
  output logic              flag_bad
);
  logic [WORD_W-1:0] hit;

  assign addr_bad = word[ADDR_LSB +: ADDR_W] != exp_addr;

  for (genvar i = 0; i < WORD_W; i++) begin : g_flag
    assign hit[i] = FLAG_MASK[i] & word[i];
  end

  assign flag_bad = |hit;
endmodule

// File: rtl/bc_stat_seq.sv
module bc_stat_seq
  import bcs_pkg::*;
#(
  parameter int TO_CYC = 224,
  parameter int WC_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_n,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              dec_err,
  input  logic              rx_stat_valid,
  input  logic [WORD_W-1:0] rx_stat,
  input  logic              wd_valid,
  output logic              wd_ready,
  input  logic [WORD_W-1:0] wd_data,
  output logic              od_valid,
  input  logic              od_ready,
  output logic [WORD_W-1:0] od_data,
  output logic              som,
  output logic              eom_n,
  output logic              last_word,
  output logic              timeout,
  output logic              stat_err,
  output logic              msg_err
);
  bcs_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              dir_q;
  logic [WC_W-1:0]   wc_q;
  logic              som_q, lw_q, to_q, se_q, me_q;

  logic start_fire, in_data, step, last, expire;
  logic addr_bad, flag_bad, stat_take, to_fire, se_fire;

  assign start_fire = (state_q == ST_IDLE) && !start_n;
  assign in_data    = (state_q == ST_SEND) || (state_q == ST_RECV);
  assign stat_take  = (state_q == ST_WAIT) && rx_stat_valid;
  assign to_fire    = (state_q == ST_WAIT) && expire && !rx_stat_valid;
  assign se_fire    = stat_take && (addr_bad || flag_bad);

  // pass-through stream, open only during a data phase
  assign wd_ready = in_data && od_ready;
  assign od_valid = in_data && wd_valid;
  assign od_data  = wd_data;
  assign step     = wd_valid && wd_ready;

  bcs_word_cnt #(.WC_W(WC_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     ((state_q == ST_IDLE) || (state_q == ST_WAIT)),
    .wc_field (wc_q),
    .step     (step),
    .is_last  (last)
  );

  bcs_resp_timer #(.TO_CYC(TO_CYC)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (state_q == ST_WAIT),
    .expire (expire)
  );

  bcs_stat_check u_chk (
    .word     (rx_stat),
    .exp_addr (addr_q),
    .addr_bad (addr_bad),
    .flag_bad (flag_bad)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_fire) state_d = cmd_word[DIR_BIT] ? ST_WAIT : ST_SEND;
      ST_SEND: if (last)       state_d = ST_WAIT;
      ST_WAIT: begin
        if (rx_stat_valid)     state_d = dir_q ? ST_RECV : ST_END;
        else if (expire)       state_d = ST_END;
      end
      ST_RECV: if (last)       state_d = ST_END;
      ST_END:                  state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      dir_q   <= 1'b0;
      wc_q    <= '0;
      som_q   <= 1'b0;
      lw_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      som_q   <= start_fire;
      lw_q    <= last;
      if (start_fire) begin
        addr_q <= cmd_word[ADDR_LSB +: ADDR_W];
        dir_q  <= cmd_word[DIR_BIT];
        wc_q   <= cmd_word[WC_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_q <= 1'b0;
      se_q <= 1'b0;
      me_q <= 1'b0;
    end else if (start_fire) begin
      to_q <= 1'b0;
      se_q <= 1'b0;
      me_q <= 1'b0;
    end else begin
      if (to_fire) to_q <= 1'b1;
      if (se_fire) se_q <= 1'b1;
      if (to_fire || se_fire || (dec_err && state_q != ST_IDLE)) me_q <= 1'b1;
    end
  end

  assign som       = som_q;
  assign last_word = lw_q;
  assign eom_n     = (state_q != ST_END);
  assign timeout   = to_q;
  assign stat_err  = se_q;
  assign msg_err   = me_q;

  a_r1_som_after_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !start_n) |=> som);
  a_r1_som_single: assert property (@(posedge clk) disable iff (!rst_n)
    som |=> !som);
  a_r2_stream_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT || state_q == ST_IDLE || state_q == ST_END) |-> (!wd_ready && !od_valid));
  a_r4_last_single: assert property (@(posedge clk) disable iff (!rst_n)
    last_word |=> !last_word);
  a_r6_bad_addr_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && rx_stat_valid && rx_stat[ADDR_LSB +: ADDR_W] != addr_q) |=> stat_err);
  a_r8_msg_err_covers: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout || stat_err) |-> msg_err);
  a_r9_eom_single: assert property (@(posedge clk) disable iff (!rst_n)
    !eom_n |=> eom_n);
  a_r9_flags_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start_n) |=> ($stable(timeout) && $stable(stat_err) && $stable(msg_err)));
endmodule

// File: tb/bc_stat_seq_test.sv
module bc_stat_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int TO_CYC     = 224;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_n = 1'b1;
  logic [15:0] cmd_word = '0;
  logic        dec_err = 1'b0;
  logic        rx_stat_valid = 1'b0;
  logic [15:0] rx_stat = '0;
  logic        wd_valid = 1'b0;
  logic        wd_ready;
  logic [15:0] wd_data = '0;
  logic        od_valid;
  logic        od_ready = 1'b0;
  logic [15:0] od_data;
  logic        som, eom_n, last_word, timeout, stat_err, msg_err;

  int n_chk = 0;
  int n_err = 0;
  int cyc_total = 0;

  bc_stat_seq #(.TO_CYC(TO_CYC), .WC_W(5)) uut (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .cmd_word(cmd_word),
    .dec_err(dec_err), .rx_stat_valid(rx_stat_valid), .rx_stat(rx_stat),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .od_valid(od_valid), .od_ready(od_ready), .od_data(od_data),
    .som(som), .eom_n(eom_n), .last_word(last_word),
    .timeout(timeout), .stat_err(stat_err), .msg_err(msg_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit stat_bad(input logic [15:0] cmd, input logic [15:0] st);
    return (st[15:11] != cmd[15:11]) || ((st & 16'h071F) != 16'h0000);
  endfunction

  // model phases: 1 send, 2 status window, 3 receive, 4 end
  task automatic run_msg(input logic [15:0] cmd, input int stat_at,
                         input logic [15:0] st, input bit inj, input int bp);
    bit  tr = cmd[10];
    int  total = (cmd[4:0] == 5'd0) ? 32 : int'(cmd[4:0]);
    int  mph, cnt = 0, wcyc = 0, cyc = 1;
    bit  lw_exp = 0, exp_to = 0, exp_se = 0, hs, indata, took;
    start_n  = 1'b0;
    cmd_word = cmd;
    @(posedge clk); #1;
    mph = tr ? 2 : 1;
    while (1) begin
      wd_valid = ($urandom_range(99) >= bp);
      od_ready = ($urandom_range(99) >= bp);
      wd_data  = 16'($urandom);
      start_n  = ($urandom_range(7) != 0);
      dec_err  = inj && (cyc == 1);
      cmd_word = 16'($urandom);
      if (mph == 2) begin
        wcyc++;
        rx_stat_valid = (wcyc == stat_at);
        rx_stat = st;
      end else begin
        rx_stat_valid = ($urandom_range(3) == 0);
        rx_stat = 16'hFFFF;
      end
      took = rx_stat_valid;
      @(negedge clk);
      indata = (mph == 1) || (mph == 3);
      chk(som == (cyc == 1), "R1", "som", som, cyc == 1);
      if (cyc == 1) begin
        chk(!timeout && !stat_err && !msg_err, "R1", "flags cleared at launch",
            {timeout, stat_err, msg_err}, 0);
      end
      chk(last_word == lw_exp, "R4", "last_word", last_word, lw_exp);
      chk(eom_n == (mph != 4), "R9", "eom_n", eom_n, mph != 4);
      chk(wd_ready == (indata && od_ready), "R2", "wd_ready", wd_ready, indata && od_ready);
      chk(od_valid == (indata && wd_valid), "R2", "od_valid", od_valid, indata && wd_valid);
      if (indata && wd_valid) chk(od_data == wd_data, "R2", "od_data", od_data, wd_data);
      hs = indata && wd_valid && od_ready;
      if (mph == 4) begin
        chk(timeout == exp_to, "R5", "timeout", timeout, exp_to);
        chk(stat_err == exp_se, "R6/R7", "stat_err", stat_err, exp_se);
        chk(msg_err == (exp_to || exp_se || inj), "R8", "msg_err", msg_err, exp_to || exp_se || inj);
        @(posedge clk); #1;
        break;
      end
      @(posedge clk); #1;
      cyc++;
      lw_exp = 0;
      if (mph == 1 || mph == 3) begin
        if (hs) begin
          cnt++;
          if (cnt == total) begin
            lw_exp = 1;
            cnt = 0;
            mph = (mph == 1) ? 2 : 4;
            wcyc = 0;
          end
        end
      end else if (mph == 2) begin
        if (took) begin
          exp_se = stat_bad(cmd, st);
          mph = tr ? 3 : 4;
        end else if (wcyc == TO_CYC) begin
          exp_to = 1;
          mph = 4;
        end
      end
    end
    start_n = 1'b1; wd_valid = 1'b0; od_ready = 1'b0;
    rx_stat_valid = 1'b0; dec_err = 1'b0;
    @(negedge clk);
    chk(eom_n && !som, "R9", "idle after end", {eom_n, som}, 2);
    chk(timeout == exp_to && stat_err == exp_se, "R9", "flags held after end",
        {timeout, stat_err}, {exp_to, exp_se});
    chk(msg_err == (exp_to || exp_se || inj), "R9", "msg_err held after end", msg_err,
        exp_to || exp_se || inj);
    @(posedge clk); #1;
  endtask

  function automatic logic [15:0] mk_cmd(input logic [4:0] a, input bit dir, input logic [4:0] wc);
    return {a, dir, 5'($urandom), wc};
  endfunction

  initial begin : watchdog
    while (cyc_total < 150000) begin
      @(posedge clk);
      cyc_total++;
    end
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc_total, 0);
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : stim
    logic [15:0] c;
    int flag_bits [8] = '{10, 9, 8, 4, 3, 2, 1, 0};
    void'($urandom(32'd1553));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk(!som && !last_word && eom_n, "R10", "pulses in reset", {som, last_word, eom_n}, 1);
    chk(!wd_ready && !od_valid, "R10", "stream in reset", {wd_ready, od_valid}, 0);
    chk(!timeout && !stat_err && !msg_err, "R10", "flags in reset",
        {timeout, stat_err, msg_err}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R2 R3 controller transmits 3 words, clean status
    c = mk_cmd(5'd7, 1'b0, 5'd3);
    run_msg(c, 5, {c[15:11], 11'h0}, 0, 20);
    // R3 count 0 means 32 words, terminal transmits
    c = mk_cmd(5'd12, 1'b1, 5'd0);
    run_msg(c, 3, {c[15:11], 11'h0}, 0, 10);
    c = mk_cmd(5'd1, 1'b0, 5'd0);
    run_msg(c, 1, {c[15:11], 11'h0}, 0, 0);
    // R5 no reply: exact end cycle checked per cycle
    c = mk_cmd(5'd3, 1'b1, 5'd4);
    run_msg(c, 0, 16'h0, 0, 0);
    c = mk_cmd(5'd9, 1'b0, 5'd2);
    run_msg(c, 0, 16'h0, 0, 30);
    // R5 status in the final window cycle is accepted
    c = mk_cmd(5'd5, 1'b1, 5'd1);
    run_msg(c, TO_CYC, {c[15:11], 11'h0}, 0, 0);
    // R7 reserved bits ignored
    c = mk_cmd(5'd20, 1'b0, 5'd1);
    run_msg(c, 2, {c[15:11], 3'b000, 3'b111, 5'b0}, 0, 0);
    // R6 address mismatch
    c = mk_cmd(5'd20, 1'b1, 5'd2);
    run_msg(c, 2, {5'd21, 11'h0}, 0, 0);
    // R7 each flag bit alone
    foreach (flag_bits[k]) begin
      c = mk_cmd(5'(k + 2), k[0], 5'd1);
      run_msg(c, 4, {c[15:11], 11'h0} | (16'h1 << flag_bits[k]), 0, 0);
    end
    // R8 decoder error alone
    c = mk_cmd(5'd30, 1'b0, 5'd2);
    run_msg(c, 2, {c[15:11], 11'h0}, 1, 0);

    // random mix
    for (int m = 0; m < 40; m++) begin
      int sa, r;
      logic [15:0] st;
      c = 16'($urandom);
      r = $urandom_range(99);
      if (r < 15) sa = 0;
      else sa = $urandom_range(TO_CYC, 1);
      if ($urandom_range(1) == 0) st = {c[15:11], 3'b000, 3'($urandom), 5'b0};
      else st = 16'($urandom);
      run_msg(c, sa, st, ($urandom_range(9) == 0), $urandom_range(60));
    end

    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule